// File: doc/BRIEF.md
# Reloading Down-Counter Interval Timer

This block is a programmable interval timer with a down-counter of `W` bits, 16 by default. Software writes a reload value and a set of control bits through a small write port. Once the timer is enabled and then started, it loads the reload value. It then counts down by one on every cycle in which the count-clock enable `tick` is high. The counter does not wrap from zero to all ones. On that step it loads the reload value again, sets a sticky underflow flag and inverts the toggle output.

A start can come from a software write or from a rising edge on the external trigger input. The external input passes through a two-stage synchroniser before its edges are detected. The load always happens one clock cycle after the start is detected. The interrupt line is high while the flag is set and interrupts are enabled. With reload value N, the toggle output is a square wave whose half-period is N+1 ticks.

Top module: `reload_timer`

## Requirements
- R1: After reset, `count` is 0 and `flag`, `irq` and `tout` are 0. The counter stays at 0 on ticks until it is enabled and started.
- R2: A write with `wr_sel`=1 and bits 0 (enable) and 1 (start) of `wr_data` both set starts the timer. `count` still holds its old value after the write edge and shows the reload value after the next edge.
- R3: While running and enabled, `count` falls by exactly 1 on each clock edge where `tick` is 1, and holds on edges where `tick` is 0.
- R4: A tick while `count` is 0 loads the reload value instead of 0xFFFF, sets `flag` and inverts `tout`. With reload value N, `tout` therefore changes every N+1 ticks.
- R5: `flag` is sticky. A control write with bit 3 = 0 clears it, and a control write with bit 3 = 1 leaves it unchanged. An underflow on the same edge as a clearing write leaves it set.
- R6: `irq` is 1 exactly when `flag` is 1 and the interrupt-enable bit (control bit 2) is 1.
- R7: The external trigger passes two synchroniser stages and is edge-detected on its rising edge. If `ext_trig` first reads high at edge k, `count` shows the reload value after edge k+3. Holding it high causes only one load.
- R8: A control write with bit 0 = 0 stops the counter and holds its value. While disabled, software and external triggers are ignored. Enabling again without a start does not resume counting.
- R9: A start while the timer is already running loads the reload value again (retrigger).
- R10: On the edge where a load takes place, a coincident tick does not decrement. A tick on the edge where the start is detected still decrements.
- R11: A write with `wr_sel`=0 stores `wr_data` as the reload value. It changes `count` only at the next load or underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: reload value, 1: control bits |
| wr_data | input | W | Write data; control bits: 0 enable, 1 start, 2 interrupt enable, 3 flag keep |
| ext_trig | input | 1 | Asynchronous external start, rising edge |
| tick | input | 1 | Count-clock enable, one decrement per high cycle |
| count | output | W | Current counter value |
| flag | output | 1 | Sticky underflow flag |
| irq | output | 1 | Interrupt request |
| tout | output | 1 | Toggle output, inverted on each underflow |

## Verification
The assertions assume that `tick` and the write inputs are synchronous to `clk`. They also assume that `ext_trig` may change at any cycle, since only its synchronised copy reaches the control logic. The bench drives every input half a cycle away from the active edge. It holds `ext_trig` high for at least one full cycle so the synchroniser sees each pulse. It places the clearing write and the underflow on the same edge only where it means to test that collision.

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         ext_trig,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         flag,
  output logic         irq,
  output logic         tout
);
  localparam int B_EN = 0, B_START = 1, B_IE = 2, B_KEEP = 3;

  logic [W-1:0] reload_q, cnt_q;
  logic         en_q, ie_q, flag_q, tout_q, run_q, load_q;
  logic [2:0]   ext_s;

  wire ctl_wr    = wr_en & wr_sel;
  wire rld_wr    = wr_en & ~wr_sel;
  wire en_next   = ctl_wr ? wr_data[B_EN] : en_q;
  wire ext_rise  = ext_s[1] & ~ext_s[2];
  wire trig      = ((ctl_wr & wr_data[B_START]) | ext_rise) & en_next;
  wire do_load   = load_q & en_q;
  wire step      = run_q & en_q & tick & ~load_q;
  wire underflow = step & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
      en_q     <= 1'b0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
      tout_q   <= 1'b0;
      run_q    <= 1'b0;
      load_q   <= 1'b0;
      ext_s    <= '0;
    end else begin
      ext_s  <= {ext_s[1:0], ext_trig};
      load_q <= trig;
      if (rld_wr) reload_q <= wr_data;
      if (ctl_wr) begin
        en_q <= wr_data[B_EN];
        ie_q <= wr_data[B_IE];
      end
      if (!en_next)     run_q <= 1'b0;
      else if (do_load) run_q <= 1'b1;
      if (do_load || underflow) cnt_q <= reload_q;
      else if (step)            cnt_q <= cnt_q - 1'b1;
      if (underflow)                         flag_q <= 1'b1;
      else if (ctl_wr && !wr_data[B_KEEP])   flag_q <= 1'b0;
      if (underflow) tout_q <= ~tout_q;
    end
  end

  assign count = cnt_q;
  assign flag  = flag_q;
  assign irq   = flag_q & ie_q;
  assign tout  = tout_q;
endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ctl_wr,
  input logic         keep_bit,
  input logic         tick,
  input logic [W-1:0] count,
  input logic         flag,
  input logic         irq,
  input logic         tout,
  input logic         en_q,
  input logic         run_q,
  input logic         load_q,
  input logic [W-1:0] reload_q
);
  p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_q && en_q) |-> count == $past(reload_q));

  p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_q && en_q && tick && !load_q && count != '0) |-> count == $past(count) - 1'b1);

  p_toggle_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tout) |-> (count == $past(reload_q)) && flag);

  p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(ctl_wr && !keep_bit));

  p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  p_hold_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_q) |-> $stable(count));
endmodule

bind reload_timer reload_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .keep_bit(wr_data[B_KEEP]),
  .tick(tick), .count(count), .flag(flag), .irq(irq), .tout(tout),
  .en_q(en_q), .run_q(run_q), .load_q(load_q), .reload_q(reload_q)
);

// File: tb/sim_reload_timer.sv
module sim_reload_timer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 0, wr_sel = 0, ext_trig = 0, tick = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic        flag, irq, tout;

  reload_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ext_trig(ext_trig), .tick(tick), .count(count),
    .flag(flag), .irq(irq), .tout(tout));

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    int          at;
    string       tag;
    logic [15:0] c;
    logic        f, t, i;
  } exp_t;

  exp_t q[$];
  int   cyc = 0, total = 0, bad = 0;
  bit   ended = 0;
  logic ef = 0, et = 0, ei = 0;

  always @(negedge clk) begin
    exp_t e;
    cyc++;
    while (q.size() > 0 && q[0].at == cyc) begin
      e = q.pop_front();
      total++;
      if (count !== e.c || flag !== e.f || tout !== e.t || irq !== e.i) begin
        bad++;
        $display("FAIL %s cyc=%0d: cnt=%0d flag=%b tout=%b irq=%b expected cnt=%0d flag=%b tout=%b irq=%b",
                 e.tag, cyc, count, flag, tout, irq, e.c, e.f, e.t, e.i);
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic slot();
    @(negedge clk); #1;
  endtask

  task automatic push_full(int k, string tag, logic [15:0] c, logic f, logic t, logic i);
    exp_t e;
    e.at = cyc + k; e.tag = tag; e.c = c; e.f = f; e.t = t; e.i = i;
    q.push_back(e);
  endtask

  task automatic push(int k, string tag, logic [15:0] c);
    push_full(k, tag, c, ef, et, ei);
  endtask

  task automatic idle();
    wr_en = 0; wr_sel = 0; wr_data = '0;
  endtask

  task automatic wr_ctl(logic en, logic st, logic ie, logic keep);
    wr_en = 1; wr_sel = 1; wr_data = {12'd0, keep, ie, st, en};
  endtask

  task automatic wr_rld(logic [15:0] v);
    wr_en = 1; wr_sel = 0; wr_data = v;
  endtask

  initial begin
    repeat (3) slot();
    rst_n = 1;
    // R1: reset state, ticks before any start
    push(1, "R1", 0);
    tick = 1;
    push(2, "R1", 0); push(3, "R1", 0);
    repeat (3) slot();
    tick = 0;

    wr_rld(16'd5); slot(); idle();
    // R2: enable and start in one write
    wr_ctl(1, 1, 1, 1);
    push(1, "R2 before load", 0); push(2, "R2 loaded", 5);
    slot(); idle(); slot();
    push(1, "R3 hold", 5); push(3, "R3 hold", 5);
    repeat (3) slot();

    // R3 and R4: count down, underflow reload, toggle half-period N+1
    tick = 1;
    for (int k = 1; k <= 12; k++)
      push_full(k, (k % 6 == 0) ? "R4 underflow" : "R3 decrement",
                16'(5 - (k % 6)), k >= 6, (k >= 6 && k < 12), k >= 6);
    repeat (12) slot();
    tick = 0;
    ef = 1; et = 0; ei = 1;

    // R5: keep and clear
    wr_ctl(1, 0, 1, 1); push(1, "R5 keep", 5); slot();
    wr_ctl(1, 0, 1, 0); ef = 0; ei = 0; push(1, "R5 clear", 5); slot(); idle();

    // R5 set over clear, R6 masked
    tick = 1;
    for (int k = 1; k <= 5; k++) push(k, "R3 decrement", 16'(5 - k));
    repeat (5) slot();
    wr_ctl(1, 0, 0, 0);
    push_full(1, "R5 set wins over clear / R6 masked", 5, 1, 1, 0);
    slot(); idle(); tick = 0;
    ef = 1; et = 1; ei = 0;
    wr_ctl(1, 0, 1, 1); ei = 1; push(1, "R6 irq enabled", 5); slot(); idle();

    // R11: reload write alone does not move the counter
    wr_rld(16'd9); push(1, "R11", 5); push(2, "R11", 5); slot(); idle(); slot();

    // R8: stop, hold, ignore triggers, no resume without start
    wr_ctl(0, 0, 1, 1); slot(); idle(); tick = 1;
    push(1, "R8 hold", 5); push(2, "R8 hold", 5); push(3, "R8 hold", 5);
    repeat (3) slot();
    wr_ctl(0, 1, 1, 1);
    push(1, "R8 sw start ignored", 5); push(3, "R8 sw start ignored", 5);
    slot(); idle(); slot(); slot();
    ext_trig = 1; slot(); ext_trig = 0;
    push(5, "R8 ext start ignored", 5); repeat (5) slot();
    wr_ctl(1, 0, 1, 1);
    push(2, "R8 no resume", 5); push(3, "R8 no resume", 5);
    slot(); idle(); slot(); slot(); tick = 0;

    // R7: synchronised rising-edge trigger
    ext_trig = 1;
    push(3, "R7 before load", 5); push(4, "R7 loaded", 9);
    repeat (4) slot();
    tick = 1;
    push(1, "R7 single load", 8); push(2, "R7 single load", 7); push(3, "R7 single load", 6);
    repeat (3) slot();
    tick = 0; ext_trig = 0;
    push(2, "R7 single load", 6); repeat (2) slot();

    // R9 retrigger, R10 load beats tick
    wr_rld(16'd3); slot(); idle();
    tick = 1; wr_ctl(1, 1, 1, 1);
    push(1, "R10 tick on detect edge", 5); push(2, "R9 retrigger", 3); push(3, "R10 after load", 2);
    slot(); idle(); slot(); slot(); tick = 0;
    repeat (3) slot();

    if (q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard left=%0d expected left=0", q.size());
    end
    finish_run();
  end
endmodule